// File: doc/BRIEF.md
# Low-Speed Operating-System Tick Down-Counter

This block is a 32-bit down-counting timer meant to run from a slow 32.768 kHz clock and to produce the periodic tick of an operating system. Software reaches it through a plain single-cycle register bus. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. Every access is accepted at once, so the bus has no back-pressure and needs no valid/ready pair.

Software stores a start value in the preload register. It then sets the enable and start bits together, and the count takes the preload on the following tick. From there the counter steps down by one per tick. When it reaches zero it raises a sticky terminal flag, which drives the interrupt pin when the interrupt enable is on. With auto-reload on, the counter takes the preload again on the tick after zero and keeps running. A new preload written while the counter runs waits for that reload. The count freezes while either of two halt sources is active:
- a firmware halt bit in the control register;
- an external debugger-halt input, which only counts when a control bit allows it.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, preload, count, status and interrupt-enable registers all read 0, and `irq_o` and `busy_o` are low.
- R2: Register map on `bus_addr`:
  - 0 is control: bit 0 enable, bit 1 auto-reload, bit 2 start, bit 3 debug-halt allow, bit 4 firmware halt.
  - 1 is preload.
  - 2 is count, which is read-only; writes to it are ignored.
  - 3 is status, with bit 0 as the terminal flag.
  - 4 is interrupt enable, in bit 0.
  - Addresses 5 to 7 read 0.
  - Unused bits read 0.
- R3: A control write that sets enable and start while start was clear loads the preload into the count on the next tick. The count then drops by one per running tick, and the full 0xFFFFFFFF load value is supported.
- R4: When the count steps from 1 to 0, status bit 0 is set. With auto-reload off, the count then stays at 0 and the start bit clears itself on that same tick.
- R5: With auto-reload on, the running tick after the count reaches 0 loads the preload again, and the start bit stays set.
- R6: Writing the preload while the counter runs leaves the count unchanged. The new value is used at the next auto-reload.
- R7: Clearing the start bit freezes the count from the next tick. The start bit reads back as written.
- R8: While the firmware halt bit is set, the count holds. Clearing the bit resumes counting from the held value.
- R9: The debugger-halt input freezes the count only while control bit 3 is set. With bit 3 clear the input is ignored.
- R10: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged. A terminal event in the same tick as a clear wins over the clear.
- R11: `irq_o` is high exactly when the terminal flag and the interrupt enable are both set.
- R12: Clearing enable clears the start bit at the write, and the count is 0 on the tick after enable is seen low.
- R13: `busy_o` is high whenever the count is nonzero.
- R14: The stop-and-load sequence produces a clean start from the new value even when the counter was running before. The sequence is: control written 0, then enable alone, then the new preload, then 0x05.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock, one tick per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| dbg_halt_i | input | 1 | Debugger holds the processor |
| irq_o | output | 1 | Terminal interrupt request |
| busy_o | output | 1 | Count is nonzero |

## Verification
The bench aims at the cycle in which each change lands.

- **Start timing.** A design that loads at the start write itself, or one tick late, shows a count that is off by one at the first sample after start.
- **Deferred preload.** If a preload write while running is copied straight into the count, the sampled count jumps.
- **Reload period.** If the reload happens on the zero tick itself, the tick period is one short.
- **Halt sources.** A debugger input that ignores its gating bit stops a count that should keep moving.
- **Firmware resume.** A firmware halt that restarts from the preload shows the wrong resumed value.
- **Flags and disable.** The bench also checks that the status clear is write-one-only, that a disable zeroes the count, and that the interrupt follows its enable.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int TK_ADDR_W = 3;
  localparam int TK_CTRL_W = 5;

  typedef enum logic [TK_ADDR_W-1:0] {
    REG_CTRL    = 3'd0,
    REG_PRELOAD = 3'd1,
    REG_COUNT   = 3'd2,
    REG_STATUS  = 3'd3,
    REG_IEN     = 3'd4
  } tk_reg_e;

  // packed: fw_halt is bit 4, enable bit 0
  typedef struct packed {
    logic fw_halt;
    logic dbg_gate;
    logic start;
    logic reload;
    logic enable;
  } tk_ctrl_t;
endpackage

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [TK_ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]     bus_wdata,
  output logic [CNT_W-1:0]     bus_rdata,
  input  logic [CNT_W-1:0]     count_i,
  input  logic                 term_set_i,
  input  logic                 stop_req_i,
  output tk_ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]     preload_o,
  output logic                 load_req_o,
  output logic                 irq_o
);
  tk_ctrl_t         ctrl_q, ctrl_wr;
  logic [CNT_W-1:0] preload_q;
  logic             term_q, ien_q;
  logic             wr_ctrl, wr_pre, wr_stat, wr_ien;

  assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
  assign wr_pre  = bus_wr && (bus_addr == REG_PRELOAD);
  assign wr_stat = bus_wr && (bus_addr == REG_STATUS);
  assign wr_ien  = bus_wr && (bus_addr == REG_IEN);

  always_comb begin
    ctrl_wr = tk_ctrl_t'(bus_wdata[TK_CTRL_W-1:0]);
    // start cannot stay set without enable
    if (!ctrl_wr.enable) ctrl_wr.start = 1'b0;
  end

  assign load_req_o = wr_ctrl && ctrl_wr.start && !ctrl_q.start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      preload_q <= '0;
      term_q    <= 1'b0;
      ien_q     <= 1'b0;
    end else begin
      if (wr_ctrl)         ctrl_q       <= ctrl_wr;
      else if (stop_req_i) ctrl_q.start <= 1'b0;
      if (wr_pre) preload_q <= bus_wdata;
      if (wr_ien) ien_q     <= bus_wdata[0];
      if (term_set_i)                      term_q <= 1'b1;
      else if (wr_stat && bus_wdata[0])    term_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CTRL:    bus_rdata[TK_CTRL_W-1:0] = ctrl_q;
      REG_PRELOAD: bus_rdata = preload_q;
      REG_COUNT:   bus_rdata = count_i;
      REG_STATUS:  bus_rdata[0] = term_q;
      REG_IEN:     bus_rdata[0] = ien_q;
      default:     bus_rdata = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign preload_o = preload_q;
  assign irq_o     = term_q & ien_q;

  assert_terminal_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    term_set_i |=> term_q);
  assert_oneshot_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req_i && !wr_ctrl) |=> !ctrl_q.start);
  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0] && !term_set_i) |=> !term_q);
endmodule

// File: rtl/tick_counter.sv
module tick_counter
  import tick_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tk_ctrl_t         ctrl_i,
  input  logic             dbg_halt_i,
  input  logic [CNT_W-1:0] preload_i,
  input  logic             load_req_i,
  output logic [CNT_W-1:0] count_o,
  output logic             term_set_o,
  output logic             stop_req_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q, count_d;
  logic             load_pend_q;
  logic             halt, run, at_one, at_zero;

  assign halt    = ctrl_i.fw_halt | (ctrl_i.dbg_gate & dbg_halt_i);
  assign run     = ctrl_i.enable & ctrl_i.start & ~halt & ~load_pend_q;
  assign at_one  = (count_q == ONE);
  assign at_zero = (count_q == '0);

  assign term_set_o = run && (at_one || (at_zero && !ctrl_i.reload));
  assign stop_req_o = run && !ctrl_i.reload && (at_one || at_zero);

  always_comb begin
    count_d = count_q;
    if (!ctrl_i.enable)   count_d = '0;
    else if (load_pend_q) count_d = preload_i;
    else if (run) begin
      if (!at_zero)            count_d = count_q - ONE;
      else if (ctrl_i.reload)  count_d = preload_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q     <= '0;
      load_pend_q <= 1'b0;
    end else begin
      count_q     <= count_d;
      load_pend_q <= load_req_i;
    end
  end

  assign count_o = count_q;

  assert_disable_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_i.enable |=> (count_q == '0));
  assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.enable && !load_pend_q && halt) |=> $stable(count_q));
  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_zero) |=> (count_q == $past(count_q) - ONE));
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && at_zero && ctrl_i.reload) |=> (count_q == $past(preload_i)));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [TK_ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]     bus_wdata,
  output logic [CNT_W-1:0]     bus_rdata,
  input  logic                 dbg_halt_i,
  output logic                 irq_o,
  output logic                 busy_o
);
  tk_ctrl_t         ctrl;
  logic [CNT_W-1:0] preload, count;
  logic             load_req, term_set, stop_req;

  tick_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .count_i    (count),
    .term_set_i (term_set),
    .stop_req_i (stop_req),
    .ctrl_o     (ctrl),
    .preload_o  (preload),
    .load_req_o (load_req),
    .irq_o      (irq_o)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_i     (ctrl),
    .dbg_halt_i (dbg_halt_i),
    .preload_i  (preload),
    .load_req_i (load_req),
    .count_o    (count),
    .term_set_o (term_set),
    .stop_req_o (stop_req)
  );

  assign busy_o = (count != '0);

  assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> ##1 (count == $past(preload)));
endmodule

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_halt_i = 1'b0;
  logic        irq_o, busy_o;
  int          n_chk = 0;
  int          n_fail = 0;

  localparam logic [2:0] A_CTRL = 3'd0, A_PRE = 3'd1, A_CNT = 3'd2,
                         A_STAT = 3'd3, A_IEN = 3'd4;

  always #10 clk = ~clk;

  tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt_i(dbg_halt_i),
    .irq_o(irq_o), .busy_o(busy_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rchk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    rchk("R1 ctrl", A_CTRL, 0); rchk("R1 preload", A_PRE, 0);
    rchk("R1 count", A_CNT, 0); rchk("R1 status", A_STAT, 0);
    rchk("R1 ien", A_IEN, 0);
    chk("R1 irq", {31'd0, irq_o}, 0); chk("R1 busy", {31'd0, busy_o}, 0);
  endtask

  task automatic t_map;
    wr(A_PRE, 32'hA5A5_0007); rchk("R2 preload rb", A_PRE, 32'hA5A5_0007);
    wr(A_IEN, 32'hFFFF_FFFF); rchk("R2 ien rb", A_IEN, 1);
    wr(A_IEN, 0);
    wr(A_CNT, 32'h1234);      rchk("R2 count read-only", A_CNT, 0);
    for (int a = 5; a < 8; a++) rchk("R2 unmapped", 3'(a), 0);
    wr(A_CTRL, 32'hFFFF_FFE3); rchk("R2 ctrl upper bits", A_CTRL, 3);
    wr(A_CTRL, 0);
  endtask

  task automatic t_oneshot;
    wr(A_PRE, 3);
    wr(A_CTRL, 5);            rchk("R3 no load at write", A_CNT, 0);
    tick(1);                  rchk("R3 load next tick", A_CNT, 3);
    chk("R13 busy", {31'd0, busy_o}, 1);
    tick(1);                  rchk("R3 step", A_CNT, 2);
    tick(2);                  rchk("R4 zero", A_CNT, 0);
    rchk("R4 status set", A_STAT, 1);
    rchk("R4 start self-clear", A_CTRL, 1);
    chk("R13 busy low", {31'd0, busy_o}, 0);
    tick(3);                  rchk("R4 holds zero", A_CNT, 0);
    wr(A_STAT, 0);            rchk("R10 write 0 keeps", A_STAT, 1);
    wr(A_STAT, 1);            rchk("R10 write 1 clears", A_STAT, 0);
  endtask

  task automatic t_max;
    wr(A_CTRL, 0); wr(A_PRE, 32'hFFFF_FFFF); wr(A_CTRL, 5);
    tick(1); rchk("R3 max load", A_CNT, 32'hFFFF_FFFF);
    tick(1); rchk("R3 max step", A_CNT, 32'hFFFF_FFFE);
    wr(A_CTRL, 0);
    tick(1); rchk("R12 disable zeroes", A_CNT, 0);
    rchk("R12 start cleared", A_CTRL, 0);
  endtask

  task automatic t_reload;
    wr(A_PRE, 2); wr(A_IEN, 1); wr(A_CTRL, 7);
    chk("R11 irq idle", {31'd0, irq_o}, 0);
    tick(1); rchk("R5 load", A_CNT, 2);
    wr(A_PRE, 5); rchk("R6 count unaffected", A_CNT, 1);
    tick(1); rchk("R5 zero", A_CNT, 0);
    chk("R11 irq raised", {31'd0, irq_o}, 1);
    rchk("R5 start kept", A_CTRL, 7);
    tick(1); rchk("R6 new preload at reload", A_CNT, 5);
    wr(A_STAT, 1); rchk("R10 cleared", A_STAT, 0);
    chk("R11 irq low", {31'd0, irq_o}, 0);
    rchk("R5 running", A_CNT, 4);
  endtask

  task automatic t_stop;
    wr(A_CTRL, 3); rchk("R7 last step", A_CNT, 3);
    rchk("R7 start rb", A_CTRL, 3);
    tick(4); rchk("R7 frozen", A_CNT, 3);
    wr(A_CTRL, 7); rchk("R7 restart pending", A_CNT, 3);
    tick(1); rchk("R7 restart load", A_CNT, 5);
  endtask

  task automatic t_fwhalt;
    wr(A_CTRL, 32'h17); rchk("R8 last step", A_CNT, 4);
    tick(3); rchk("R8 held", A_CNT, 4);
    wr(A_CTRL, 7); rchk("R8 still held", A_CNT, 4);
    tick(1); rchk("R8 resumed", A_CNT, 3);
  endtask

  task automatic t_dbg;
    dbg_halt_i = 1'b1;
    tick(1); rchk("R9 ungated ignored", A_CNT, 2);
    wr(A_CTRL, 32'h0F); rchk("R9 last step", A_CNT, 1);
    tick(2); rchk("R9 halted", A_CNT, 1);
    dbg_halt_i = 1'b0;
    tick(1); rchk("R9 resumed", A_CNT, 0);
    wr(A_CTRL, 0); wr(A_STAT, 1);
  endtask

  task automatic t_seq;
    wr(A_PRE, 9); wr(A_CTRL, 5); tick(2);
    rchk("R14 running", A_CNT, 8);
    wr(A_CTRL, 0); wr(A_CTRL, 1); wr(A_PRE, 4); wr(A_CTRL, 5);
    tick(1); rchk("R14 new load", A_CNT, 4);
    tick(1); rchk("R14 counting", A_CNT, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_map; t_oneshot; t_max; t_reload; t_stop; t_fwhalt; t_dbg; t_seq;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule